// File: doc/BRIEF.md
# Paged Bit-Address Generator

This block turns a three-part location (a page group, a page inside that group, and a bit offset inside that page) into one flat bit address in a wide memory. Pages are 833,850 bits long. That size is not a power of two, so the fields cannot simply be concatenated without leaving large holes in memory. The block instead multiplies the combined page index by the page size over several clock cycles, using one shift-and-add step per index bit. It then adds the offset and splits the 35-bit result into two parts: a word address for a 512-bit-wide memory and a 9-bit index that picks one bit out of that word.

A one-cycle start pulse latches the inputs. The result appears together with a one-cycle done pulse a fixed number of cycles later, which is well inside a 20-cycle budget at 50 MHz. An out-of-range flag marks offsets or page numbers that lie past their legal range. The arithmetic is still carried out for those inputs.

Top module: `pgaddr_top`

## Requirements
- R1: On done, the concatenation {word_o, bit_o} equals ((grp_i·16 + page_i)·833850 + ofs_i) mod 2^35, using the inputs sampled at start. word_o holds bits 34..9 and bit_o holds bits 8..0.
- R2: A start accepted at a rising edge causes done_o to be high for exactly one cycle. That cycle begins 12 rising edges after the accepting edge.
- R3: busy_o is high from the cycle after an accepted start until the cycle before done_o. busy_o is low while done_o is high.
- R4: A start pulse that arrives while busy_o is high is ignored. No second done_o follows it, and the result reflects only the first start.
- R5: Changing grp_i, page_i or ofs_i while busy_o is high has no effect on the result.
- R6: oob_o is set at done when ofs_i ≥ 833850 or page_i ≥ 16 (page_i is 5 bits wide). Otherwise oob_o is clear. The address is produced in either case.
- R7: A synchronous reset clears busy_o, done_o and oob_o, and sets word_o and bit_o to zero. This also applies when the reset arrives in the middle of a calculation.
- R8: word_o, bit_o and oob_o hold their values from done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request; accepted only while idle |
| grp_i | input | 6 | Page group |
| page_i | input | 5 | Page within group (legal 0..15) |
| ofs_i | input | 20 | Bit offset within page (legal 0..833849) |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| oob_o | output | 1 | Offset or page out of range |
| word_o | output | 26 | Memory word address (512-bit words) |
| bit_o | output | 9 | Bit index within the word |

## Verification
The assertions assume that reset is held for at least one clock and that start is a synchronous level sampled at rising edges. They do not assume that start stays low while the block is busy; the latency and hold properties must survive stray starts. The bench changes every input only on falling edges. It deliberately fires start and changes the inputs in the middle of a calculation, so the latency counter and the stability properties are exercised under those conditions.

// File: rtl/pgaddr_pkg.sv
package pgaddr_pkg;
  localparam int unsigned PAGE_BITS_DEF = 833850;
  localparam int unsigned GRP_W_DEF     = 6;
  localparam int unsigned PG_W_DEF      = 5;
  localparam int unsigned PG_SHIFT_DEF  = 4;
  localparam int unsigned OFS_W_DEF     = 20;
  localparam int unsigned ADDR_W_DEF    = 35;
  localparam int unsigned BIT_W_DEF     = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_ADD  = 2'd2
  } mac_state_e;
endpackage

// File: rtl/pgaddr_capture.sv
module pgaddr_capture #(
  parameter int unsigned GRP_W     = pgaddr_pkg::GRP_W_DEF,
  parameter int unsigned PG_W      = pgaddr_pkg::PG_W_DEF,
  parameter int unsigned PG_SHIFT  = pgaddr_pkg::PG_SHIFT_DEF,
  parameter int unsigned OFS_W     = pgaddr_pkg::OFS_W_DEF,
  parameter int unsigned PAGE_BITS = pgaddr_pkg::PAGE_BITS_DEF,
  parameter int unsigned IDX_W     = GRP_W + PG_SHIFT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [GRP_W-1:0] grp,
  input  logic [PG_W-1:0]  page,
  input  logic [OFS_W-1:0] ofs,
  output logic [IDX_W-1:0] idx,
  output logic [OFS_W-1:0] ofs_q,
  output logic             oob_q
);
  localparam logic [OFS_W-1:0] PAGE_LIM = OFS_W'(PAGE_BITS);
  localparam logic [PG_W-1:0]  PG_LIM   = PG_W'(1 << PG_SHIFT);

  // flat page index: group scaled by pages per group, plus page
  function automatic logic [IDX_W-1:0] page_index(input logic [GRP_W-1:0] g,
                                                   input logic [PG_W-1:0]  p);
    return IDX_W'({g, {PG_SHIFT{1'b0}}}) + IDX_W'(p);
  endfunction

  function automatic logic range_bad(input logic [PG_W-1:0]  p,
                                     input logic [OFS_W-1:0] o);
    return (o >= PAGE_LIM) || (p >= PG_LIM);
  endfunction

  assign idx = page_index(grp, page);

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
      oob_q <= 1'b0;
    end else if (load) begin
      ofs_q <= ofs;
      oob_q <= range_bad(page, ofs);
    end
  end
endmodule

// File: rtl/pgaddr_mac.sv
module pgaddr_mac
  import pgaddr_pkg::*;
#(
  parameter int unsigned IDX_W     = 11,
  parameter int unsigned OFS_W     = pgaddr_pkg::OFS_W_DEF,
  parameter int unsigned ADDR_W    = pgaddr_pkg::ADDR_W_DEF,
  parameter int unsigned PAGE_BITS = pgaddr_pkg::PAGE_BITS_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] acc,
  output logic              busy,
  output logic              done,
  output logic              mul_step,
  output logic              add_step
);
  localparam int unsigned CNT_W = $clog2(IDX_W + 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(IDX_W - 1);
  localparam logic [ADDR_W-1:0] PAGE_V   = ADDR_W'(PAGE_BITS);

  mac_state_e        st;
  logic [IDX_W-1:0]  sh;
  logic [CNT_W-1:0]  cnt;

  // one multiplier step, index MSB first
  function automatic logic [ADDR_W-1:0] mac_step(input logic [ADDR_W-1:0] a,
                                                 input logic              b);
    return {a[ADDR_W-2:0], 1'b0} + (b ? PAGE_V : '0);
  endfunction

  assign busy     = (st != ST_IDLE);
  assign mul_step = (st == ST_MUL);
  assign add_step = (st == ST_ADD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      acc  <= '0;
      sh   <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            sh  <= idx;
            acc <= '0;
            cnt <= '0;
            st  <= ST_MUL;
          end
        end
        ST_MUL: begin
          acc <= mac_step(acc, sh[IDX_W-1]);
          sh  <= {sh[IDX_W-2:0], 1'b0};
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) st <= ST_ADD;
        end
        ST_ADD: begin
          acc  <= acc + ADDR_W'(ofs);
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgaddr_top.sv
module pgaddr_top #(
  parameter int unsigned GRP_W     = pgaddr_pkg::GRP_W_DEF,
  parameter int unsigned PG_W      = pgaddr_pkg::PG_W_DEF,
  parameter int unsigned PG_SHIFT  = pgaddr_pkg::PG_SHIFT_DEF,
  parameter int unsigned OFS_W     = pgaddr_pkg::OFS_W_DEF,
  parameter int unsigned ADDR_W    = pgaddr_pkg::ADDR_W_DEF,
  parameter int unsigned BIT_W     = pgaddr_pkg::BIT_W_DEF,
  parameter int unsigned PAGE_BITS = pgaddr_pkg::PAGE_BITS_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [GRP_W-1:0]        grp_i,
  input  logic [PG_W-1:0]         page_i,
  input  logic [OFS_W-1:0]        ofs_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    oob_o,
  output logic [ADDR_W-BIT_W-1:0] word_o,
  output logic [BIT_W-1:0]        bit_o
);
  localparam int unsigned IDX_W = GRP_W + PG_SHIFT + 1;

  logic              accept_evt;
  logic              mul_evt;
  logic              add_evt;
  logic [IDX_W-1:0]  idx_w;
  logic [OFS_W-1:0]  ofs_w;
  logic [ADDR_W-1:0] acc_w;

  assign accept_evt = start && !busy_o;

  pgaddr_capture #(
    .GRP_W(GRP_W), .PG_W(PG_W), .PG_SHIFT(PG_SHIFT),
    .OFS_W(OFS_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)
  ) u_cap (
    .clk(clk), .rst(rst), .load(accept_evt),
    .grp(grp_i), .page(page_i), .ofs(ofs_i),
    .idx(idx_w), .ofs_q(ofs_w), .oob_q(oob_o)
  );

  pgaddr_mac #(
    .IDX_W(IDX_W), .OFS_W(OFS_W), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
  ) u_mac (
    .clk(clk), .rst(rst), .go(accept_evt),
    .idx(idx_w), .ofs(ofs_w), .acc(acc_w),
    .busy(busy_o), .done(done_o),
    .mul_step(mul_evt), .add_step(add_evt)
  );

  assign word_o = acc_w[ADDR_W-1:BIT_W];
  assign bit_o  = acc_w[BIT_W-1:0];
endmodule

// File: rtl/pgaddr_chk.sv
module pgaddr_chk #(
  parameter int unsigned WORD_W = 26,
  parameter int unsigned BIT_W  = 9,
  parameter int unsigned LAT    = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              accept,
  input logic              mul_evt,
  input logic              add_evt,
  input logic              busy,
  input logic              done,
  input logic              oob,
  input logic [WORD_W-1:0] word,
  input logic [BIT_W-1:0]  bitsel
);
  logic [7:0] lat_cnt;
  logic       rst_seen;

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 8'd1;
  end

  always_ff @(posedge clk) rst_seen <= rst;

  // R7: state right after a reset cycle
  always_ff @(posedge clk) begin
    if (rst_seen && !rst) begin
      p_reset_state_r7: assert (!busy && !done && !oob && word == '0 && bitsel == '0)
        else $error("reset state violated");
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == 8'(LAT)));

  p_busy_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  p_add_then_done_r2: assert property (@(posedge clk) disable iff (rst)
    add_evt |=> done);

  p_mul_busy_r3: assert property (@(posedge clk) disable iff (rst)
    mul_evt |-> busy);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> ($stable(word) && $stable(bitsel) && $stable(oob)));
endmodule

bind pgaddr_top pgaddr_chk #(
  .WORD_W(ADDR_W - BIT_W), .BIT_W(BIT_W), .LAT(GRP_W + PG_SHIFT + 2)
) u_chk (
  .clk(clk), .rst(rst), .accept(accept_evt), .mul_evt(mul_evt),
  .add_evt(add_evt), .busy(busy_o), .done(done_o), .oob(oob_o),
  .word(word_o), .bitsel(bit_o)
);

// File: tb/pgaddr_top_tb.sv
`timescale 1ns/1ps
module pgaddr_top_tb;
  localparam longint PAGE = 833850;
  localparam int     NVEC = 10;
  // {grp[30:25], page[24:20], ofs[19:0]}
  localparam logic [30:0] VEC [NVEC] = '{
    {6'd0,  5'd0,  20'd0},
    {6'd0,  5'd0,  20'd1},
    {6'd0,  5'd1,  20'd0},
    {6'd1,  5'd0,  20'd0},
    {6'd12, 5'd7,  20'd511},
    {6'd63, 5'd15, 20'd0},
    {6'd63, 5'd15, 20'd833849},
    {6'd5,  5'd16, 20'd100},
    {6'd2,  5'd3,  20'd833850},
    {6'd63, 5'd31, 20'hFFFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  grp_i = '0;
  logic [4:0]  page_i = '0;
  logic [19:0] ofs_i = '0;
  logic        busy_o, done_o, oob_o;
  logic [25:0] word_o;
  logic [8:0]  bit_o;
  int          errors = 0;
  int          checks = 0;

  always #10 clk = ~clk;

  pgaddr_top u_dut (
    .clk(clk), .rst(rst), .start(start), .grp_i(grp_i), .page_i(page_i),
    .ofs_i(ofs_i), .busy_o(busy_o), .done_o(done_o), .oob_o(oob_o),
    .word_o(word_o), .bit_o(bit_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_addr(input longint g, input longint p, input longint o);
    return ((g * 16 + p) * PAGE + o) % (64'd1 << 35);
  endfunction

  task automatic run_op(input logic [5:0] g, input logic [4:0] p, input logic [19:0] o,
                        input bit disturb);
    longint e;
    bit     eo;
    int     n;
    e  = ref_addr(g, p, o);
    eo = (o >= PAGE) || (p >= 16);
    @(negedge clk);
    grp_i = g; page_i = p; ofs_i = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy_o == 1'b1, "R3 busy after start", busy_o, 1);
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
      if (disturb && n == 3) begin
        start = 1'b1; grp_i = ~g; page_i = ~p; ofs_i = ~o;   // R4 / R5
      end else start = 1'b0;
    end
    chk(n == 13, "R2 latency", n, 13);
    chk(busy_o == 1'b0, "R3 busy low at done", busy_o, 0);
    chk(word_o == e[34:9], "R1 word address", word_o, e[34:9]);
    chk(bit_o == e[8:0], "R1 bit index", bit_o, e[8:0]);
    chk(oob_o == eo, "R6 range flag", oob_o, eo);
    @(negedge clk);
    chk(done_o == 1'b0, "R2 done single cycle", done_o, 0);
    if (disturb) begin
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (done_o) chk(1'b0, "R4 no second done", 1, 0);
      end
      chk(word_o == e[34:9] && bit_o == e[8:0], "R5 R8 result kept", word_o, e[34:9]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint e;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !oob_o && word_o == 0 && bit_o == 0, "R7 reset state", word_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o, "R7 idle after reset", busy_o, 0);

    for (int i = 0; i < NVEC; i++)
      run_op(VEC[i][30:25], VEC[i][24:20], VEC[i][19:0], 1'b0);

    for (int i = 0; i < 16; i++)
      run_op(6'($urandom_range(0, 63)), 5'($urandom_range(0, 15)),
             20'($urandom_range(0, 833849)), 1'b0);

    run_op(6'd33, 5'd9, 20'd777777, 1'b1);

    // R8: result holds while idle, inputs wiggling without start
    e = ref_addr(33, 9, 777777);
    grp_i = 6'd1; page_i = 5'd2; ofs_i = 20'd3;
    repeat (5) @(negedge clk);
    chk(word_o == e[34:9] && bit_o == e[8:0], "R8 hold idle", bit_o, e[8:0]);

    // R7: reset in mid-calculation
    @(negedge clk);
    grp_i = 6'd40; page_i = 5'd20; ofs_i = 20'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !oob_o && word_o == 0 && bit_o == 0, "R7 mid-run reset", busy_o, 0);
    rst = 1'b0;
    repeat (15) @(negedge clk);
    chk(!done_o && !busy_o, "R7 no leftover done", done_o, 0);

    run_op(6'd0, 5'd0, 20'd0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule